// File: doc/BRIEF.md
# Indirect Coefficient Memory Access Controller

This block lets a host reach three internal coefficient stores through a small byte-wide register port. The stores are an echo-canceller coefficient bank (64 words of 14 bits), a feedback-equalizer coefficient bank (58 words of 16 bits) and a scratch pad (64 words of 8 bits). The host never addresses a store directly. It goes through a shared 32-bit access data register, which is split into four host bytes, and through six 6-bit select registers. Each store has one select register for reading and one for writing.

Writing a select register posts a transfer request and does not perform it. The request is carried out at the next symbol-rate strobe. A write request copies the low bits of the access data register into the addressed word. A read request copies the addressed word into the access data register and clears its upper bits. A `busy` output stays high while any request is waiting or any load is still in flight. Software can therefore poll `busy` before it reads back a result.

Top module: `coef_access_ctrl`

## Requirements
- R1: After reset, every host register reads zero, every store word reads back as zero, and `busy` is low.
- R2: Host addresses 4 to 9 select, in order, echo write, echo read, equalizer write, equalizer read, scratch write and scratch read. Each keeps bits [5:0] of the last byte written, and bits [7:6] read as zero. Host reads return the addressed byte one cycle after the address is presented, and addresses above 9 read zero.
- R3: An echo write transfer stores access data bits [13:0]. A later echo read loads that 14-bit word into the access data register with bits [31:14] cleared.
- R4: An equalizer transfer moves access data bits [15:0], and a read clears bits [31:16].
- R5: An equalizer address of 58 or more is ignored. A write changes no word, including word 0, and a read loads zero.
- R6: A scratch transfer moves access data bits [7:0], and a read clears bits [31:8].
- R7: A write transfer leaves the access data register unchanged, and a read transfer leaves the store unchanged.
- R8: A request is carried out only at a strobe, and the first strobe after the request carries it out. `busy` rises on the cycle after a select write and falls once no request waits and no load is in flight.
- R9: A second write to the same select register before the strobe replaces the earlier request, so only the newer address is transferred.
- R10: If a select register is written in the same cycle as a strobe, the strobe serves the earlier address and the new address waits for the next strobe.
- R11: Write requests to different stores are all served at one strobe. Only one read is served per strobe, with echo ahead of equalizer and equalizer ahead of scratch. The other reads stay pending.
- R12: A read load reaches the access data register one cycle after its strobe. It wins over a host byte write to the access data register in that same cycle.
- R13: A write transfer stores the access data value held in the strobe cycle. A host byte write made in that same cycle does not reach the store.
- R14: Access data bytes sit at host addresses 0 to 3, with byte 0 the least significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host byte write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| sym_stb | input | 1 | Symbol-rate strobe that carries out transfers |
| busy | output | 1 | High while any transfer is pending or loading |

## Verification
The key collisions are host register traffic that lands in the same cycle as a transfer. The bench raises `sym_stb` in the same cycle as a select-register write, and checks that the old address was served and the new one still waits. It also writes an access data byte in the strobe cycle and then in the load cycle. In the strobe-cycle case the store must receive the old data. In the load-cycle case the loaded word must win. Each outcome is judged by reading the stores back through later read transfers and comparing with a bench-side model.

// File: rtl/coef_access_pkg.sv
package coef_access_pkg;
  localparam int unsigned SEL_W      = 6;
  localparam int unsigned HADDR_W    = 4;
  localparam int unsigned DATA_BYTES = 4;
  localparam int unsigned DATA_W     = 8 * DATA_BYTES;
  localparam int unsigned NUM_MEM    = 3;
  localparam int unsigned NREQ       = 2 * NUM_MEM;
  // select registers follow the data bytes; request 2m is a write, 2m+1 a read
  localparam int unsigned SEL_BASE   = DATA_BYTES;
  localparam int unsigned MEM_EC     = 0;
  localparam int unsigned MEM_FB     = 1;
  localparam int unsigned MEM_SP     = 2;
endpackage

// File: rtl/coef_mem.sv
module coef_mem #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [0:DEPTH-1];
  logic w_ok, r_ok;

  assign w_ok = {1'b0, waddr} < LIMIT;
  assign r_ok = {1'b0, raddr} < LIMIT;

  // read-first: a read and a write to the same word in one cycle return the old word
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we && w_ok) mem[waddr] <= wdata;
      rdata <= r_ok ? mem[raddr] : '0;
    end
  end
endmodule

// File: rtl/coef_req_track.sv
module coef_req_track #(
  parameter int unsigned NUM_MEM = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sym_stb,
  input  logic [2*NUM_MEM-1:0] req_set,
  output logic [NUM_MEM-1:0]   wr_go,
  output logic [NUM_MEM-1:0]   rd_go,
  output logic [2*NUM_MEM-1:0] pend_q,
  output logic [2*NUM_MEM-1:0] pend_nxt
);
  localparam int unsigned NR = 2 * NUM_MEM;

  logic [NUM_MEM-1:0] rd_pend;
  logic [NR-1:0]      served;

  for (genvar m = 0; m < NUM_MEM; m++) begin : g_mem
    assign wr_go[m]       = sym_stb & pend_q[2*m];
    assign rd_pend[m]     = pend_q[2*m+1];
    assign served[2*m]    = wr_go[m];
    assign served[2*m+1] = rd_go[m];
  end

  // lowest store index wins the single read slot of a strobe
  always_comb begin
    rd_go = '0;
    if (sym_stb) begin
      for (int m = int'(NUM_MEM) - 1; m >= 0; m--) begin
        if (rd_pend[m]) begin
          rd_go    = '0;
          rd_go[m] = 1'b1;
        end
      end
    end
  end

  // a new select write always posts, and replaces any older request of that register
  assign pend_nxt = req_set | (pend_q & ~served);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_nxt;
  end
endmodule

// File: rtl/coef_access_ctrl.sv
module coef_access_ctrl
  import coef_access_pkg::*;
#(
  parameter int unsigned EC_W     = 14,
  parameter int unsigned EC_DEPTH = 64,
  parameter int unsigned FB_W     = 16,
  parameter int unsigned FB_DEPTH = 58,
  parameter int unsigned SP_W     = 8,
  parameter int unsigned SP_DEPTH = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_we,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  input  logic               sym_stb,
  output logic               busy
);
  logic [SEL_W-1:0]   sel_q [NREQ];
  logic [DATA_W-1:0]  data_q, load_word;
  logic [NREQ-1:0]    req_set, pend_q, pend_nxt;
  logic [NUM_MEM-1:0] wr_go, rd_go, load_q;
  logic [EC_W-1:0]    ec_q;
  logic [FB_W-1:0]    fb_q;
  logic [SP_W-1:0]    sp_q;
  logic [7:0]         rd_mux;

  // select registers
  for (genvar i = 0; i < NREQ; i++) begin : g_sel
    assign req_set[i] = host_we && (host_addr == HADDR_W'(SEL_BASE + i));
    always_ff @(posedge clk) begin
      if (rst)             sel_q[i] <= '0;
      else if (req_set[i]) sel_q[i] <= host_wdata[SEL_W-1:0];
    end
  end

  coef_req_track #(.NUM_MEM(NUM_MEM)) u_trk (
    .clk(clk), .rst(rst), .sym_stb(sym_stb), .req_set(req_set),
    .wr_go(wr_go), .rd_go(rd_go), .pend_q(pend_q), .pend_nxt(pend_nxt)
  );

  coef_mem #(.WIDTH(EC_W), .DEPTH(EC_DEPTH), .AW(SEL_W)) u_ec (
    .clk(clk), .rst(rst), .we(wr_go[MEM_EC]), .waddr(sel_q[2*MEM_EC]),
    .wdata(data_q[EC_W-1:0]), .raddr(sel_q[2*MEM_EC+1]), .rdata(ec_q)
  );

  coef_mem #(.WIDTH(FB_W), .DEPTH(FB_DEPTH), .AW(SEL_W)) u_fb (
    .clk(clk), .rst(rst), .we(wr_go[MEM_FB]), .waddr(sel_q[2*MEM_FB]),
    .wdata(data_q[FB_W-1:0]), .raddr(sel_q[2*MEM_FB+1]), .rdata(fb_q)
  );

  coef_mem #(.WIDTH(SP_W), .DEPTH(SP_DEPTH), .AW(SEL_W)) u_sp (
    .clk(clk), .rst(rst), .we(wr_go[MEM_SP]), .waddr(sel_q[2*MEM_SP]),
    .wdata(data_q[SP_W-1:0]), .raddr(sel_q[2*MEM_SP+1]), .rdata(sp_q)
  );

  // zero-extended word from the store whose read was served last strobe
  always_comb begin
    load_word = '0;
    if (load_q[MEM_EC])      load_word = DATA_W'(ec_q);
    else if (load_q[MEM_FB]) load_word = DATA_W'(fb_q);
    else if (load_q[MEM_SP]) load_word = DATA_W'(sp_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      load_q <= '0;
      busy   <= 1'b0;
    end else begin
      load_q <= rd_go;
      busy   <= (|pend_nxt) | (|rd_go);
      if (|load_q) begin
        data_q <= load_word;
      end else if (host_we) begin
        for (int b = 0; b < int'(DATA_BYTES); b++)
          if (host_addr == HADDR_W'(b)) data_q[8*b +: 8] <= host_wdata;
      end
    end
  end

  // host read path
  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < int'(DATA_BYTES); b++)
      if (host_addr == HADDR_W'(b)) rd_mux = data_q[8*b +: 8];
    for (int i = 0; i < int'(NREQ); i++)
      if (host_addr == HADDR_W'(SEL_BASE + i)) rd_mux = {{(8-SEL_W){1'b0}}, sel_q[i]};
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= rd_mux;
  end
endmodule

// File: rtl/coef_access_chk.sv
module coef_access_chk
  import coef_access_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               host_we,
  input logic [HADDR_W-1:0] host_addr,
  input logic               sym_stb,
  input logic               busy,
  input logic [NREQ-1:0]    pend_q,
  input logic [NUM_MEM-1:0] rd_go,
  input logic [NUM_MEM-1:0] load_q
);
  logic sel_wr;
  assign sel_wr = host_we && (host_addr >= HADDR_W'(SEL_BASE)) &&
                  (host_addr < HADDR_W'(SEL_BASE + NREQ));

  for (genvar i = 0; i < NREQ; i++) begin : g_req
    // R8 / R9: a select write posts its request and raises busy
    a_r8_req_raises_busy: assert property (@(posedge clk) disable iff (rst)
      (host_we && host_addr == HADDR_W'(SEL_BASE + i)) |=> (busy && pend_q[i]));
  end

  // R8: nothing pending and nothing posted keeps the block idle
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (pend_q == '0 && load_q == '0 && !sel_wr) |=> !busy);

  // R8: a request only leaves the pending set at a strobe
  a_r8_serve_on_strobe: assert property (@(posedge clk) disable iff (rst)
    (|($past(pend_q) & ~pend_q)) |-> $past(sym_stb));

  // R11: one read per strobe
  a_r11_one_read: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_go));

  for (genvar m = 1; m < NUM_MEM; m++) begin : g_pri
    for (genvar j = 0; j < m; j++) begin : g_low
      // R11: a lower-index read pending blocks a higher one
      a_r11_priority: assert property (@(posedge clk) disable iff (rst)
        rd_go[m] |-> !pend_q[2*j+1]);
    end
  end

  // R12: the load follows its strobe by one cycle
  a_r12_load_follows: assert property (@(posedge clk) disable iff (rst)
    (rd_go != '0) |=> (load_q == $past(rd_go)));
endmodule

bind coef_access_ctrl coef_access_chk u_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
  .sym_stb(sym_stb), .busy(busy), .pend_q(pend_q), .rd_go(rd_go), .load_q(load_q)
);

// File: tb/coef_access_ctrl_tb_top.sv
`timescale 1ns/1ps
module coef_access_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_we = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       sym_stb = 1'b0;
  logic       busy;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [13:0] m_ec [64];
  logic [15:0] m_fb [64];
  logic [7:0]  m_sp [64];
  logic [31:0] m_data;

  always #2.5 clk = ~clk;

  coef_access_ctrl dut_i (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .sym_stb(sym_stb), .busy(busy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic set_data(input logic [31:0] v);
    for (int b = 0; b < 4; b++) wr(4'(b), v[8*b +: 8]);
    m_data = v;
  endtask

  task automatic get_data(output logic [31:0] v);
    logic [7:0] t;
    for (int b = 0; b < 4; b++) begin
      rd(4'(b), t);
      v[8*b +: 8] = t;
    end
  endtask

  task automatic stb();
    sym_stb = 1'b1;
    @(negedge clk);
    sym_stb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic req(input int k, input logic [5:0] a);
    wr(4'(4 + k), {2'b00, a});
  endtask

  function automatic logic [31:0] exp_read(input int m, input int a);
    if (m == 0) return {18'b0, m_ec[a]};
    if (m == 1) return (a < 58) ? {16'b0, m_fb[a]} : 32'h0;
    return {24'b0, m_sp[a]};
  endfunction

  function automatic void model_write(input int m, input int a);
    if (m == 0) m_ec[a] = m_data[13:0];
    else if (m == 1) begin
      if (a < 58) m_fb[a] = m_data[15:0];
    end else m_sp[a] = m_data[7:0];
  endfunction

  task automatic do_write(input int m, input int a, input logic [31:0] v);
    set_data(v);
    req(2*m, 6'(a));
    stb();
    model_write(m, a);
  endtask

  task automatic do_read(input int m, input int a, input string tag);
    logic [31:0] x;
    req(2*m + 1, 6'(a));
    stb();
    m_data = exp_read(m, a);
    get_data(x);
    check(tag, x, m_data);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  t8;
    logic [31:0] x;
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) begin m_ec[i] = '0; m_fb[i] = '0; m_sp[i] = '0; end
    m_data = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", {31'b0, busy}, 32'h0);
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), t8);
      check("R1 reg", {24'b0, t8}, 32'h0);
    end
    do_read(0, 5, "R1 echo word");
    do_read(1, 5, "R1 eq word");
    do_read(2, 5, "R1 scratch word");

    // R2 select readback, upper bits zero
    wr(4'd5, 8'hFF);
    stb();
    m_data = exp_read(0, 63);
    rd(4'd5, t8);
    check("R2 select readback", {24'b0, t8}, 32'h3F);
    rd(4'd15, t8);
    check("R2 unused address", {24'b0, t8}, 32'h0);

    // R3, R7, R14
    do_write(0, 7, 32'hFFFF_FFFF);
    get_data(x);
    check("R7 data kept after write", x, 32'hFFFF_FFFF);
    do_read(0, 7, "R3 echo 14 bits");
    set_data(32'h8877_6655);
    rd(4'd0, t8);
    check("R14 byte0", {24'b0, t8}, 32'h55);
    rd(4'd3, t8);
    check("R14 byte3", {24'b0, t8}, 32'h88);

    // R4, R5
    do_write(1, 57, 32'hA5A5_1234);
    do_read(1, 57, "R4 equalizer 16 bits");
    do_write(1, 58, 32'h0000_BEEF);
    do_read(1, 58, "R5 out of range read");
    do_read(1, 0, "R5 no wrap to word 0");
    do_read(1, 57, "R5 word 57 intact");

    // R6, R7 read does not disturb
    do_write(2, 63, 32'h1234_56C3);
    do_read(2, 63, "R6 scratch 8 bits");
    do_read(2, 63, "R7 store kept after read");

    // R8 deferred until strobe, busy tracking
    req(1, 6'd7);
    check("R8 busy after select write", {31'b0, busy}, 32'h1);
    repeat (5) @(negedge clk);
    check("R8 busy waits for strobe", {31'b0, busy}, 32'h1);
    get_data(x);
    check("R8 no transfer without strobe", x, m_data);
    stb();
    check("R8 busy clears", {31'b0, busy}, 32'h0);
    m_data = exp_read(0, 7);
    get_data(x);
    check("R8 served at strobe", x, m_data);

    // R9 newer select write replaces older
    set_data(32'h0000_1357);
    req(0, 6'd10);
    req(0, 6'd11);
    stb();
    model_write(0, 11);
    do_read(0, 10, "R9 older address untouched");
    do_read(0, 11, "R9 newer address written");

    // R10 select write in the strobe cycle
    set_data(32'h0000_2468);
    req(0, 6'd20);
    host_we = 1'b1; host_addr = 4'd4; host_wdata = 8'd21; sym_stb = 1'b1;
    @(negedge clk);
    host_we = 1'b0; sym_stb = 1'b0;
    check("R10 new request pending", {31'b0, busy}, 32'h1);
    model_write(0, 20);
    repeat (2) @(negedge clk);
    stb();
    model_write(0, 21);
    do_read(0, 20, "R10 old address served");
    do_read(0, 21, "R10 new address served next");

    // R11 one read per strobe, priority
    do_write(0, 30, 32'h0000_1111);
    do_write(1, 31, 32'h0000_2222);
    do_write(2, 32, 32'h0000_0033);
    req(5, 6'd32);
    req(3, 6'd31);
    req(1, 6'd30);
    stb();
    get_data(x);
    check("R11 echo first", x, 32'h0000_1111);
    check("R11 busy between", {31'b0, busy}, 32'h1);
    stb();
    get_data(x);
    check("R11 equalizer second", x, 32'h0000_2222);
    stb();
    get_data(x);
    check("R11 scratch third", x, 32'h0000_0033);
    check("R11 busy clears", {31'b0, busy}, 32'h0);
    // R11 writes to all stores at one strobe
    set_data(32'h0000_4C4C);
    req(0, 6'd40); req(2, 6'd40); req(4, 6'd40);
    stb();
    model_write(0, 40); model_write(1, 40); model_write(2, 40);
    do_read(0, 40, "R11 multi write echo");
    do_read(1, 40, "R11 multi write equalizer");
    do_read(2, 40, "R11 multi write scratch");

    // R12 load wins over host byte write
    req(1, 6'd30);
    sym_stb = 1'b1;
    @(negedge clk);
    sym_stb = 1'b0;
    host_we = 1'b1; host_addr = 4'd0; host_wdata = 8'hEE;
    @(negedge clk);
    host_we = 1'b0;
    repeat (2) @(negedge clk);
    m_data = exp_read(0, 30);
    get_data(x);
    check("R12 load wins", x, m_data);

    // R13 write uses data held in strobe cycle
    set_data(32'h0000_0055);
    req(4, 6'd41);
    host_we = 1'b1; host_addr = 4'd0; host_wdata = 8'hAA; sym_stb = 1'b1;
    @(negedge clk);
    host_we = 1'b0; sym_stb = 1'b0;
    repeat (3) @(negedge clk);
    model_write(2, 41);
    m_data[7:0] = 8'hAA;
    get_data(x);
    check("R13 host byte landed", x, m_data);
    do_read(2, 41, "R13 store got old data");

    // random traffic
    for (int n = 0; n < 300; n++) begin
      int m, a;
      m = $urandom_range(0, 2);
      a = $urandom_range(0, 63);
      if (m == 1 && $urandom_range(0, 3) != 0) a = $urandom_range(0, 57);
      if ($urandom_range(0, 1) == 0) begin
        do_write(m, a, $urandom());
        get_data(x);
        check("R7 random data kept", x, m_data);
      end else begin
        if (m == 0)      do_read(m, a, "R3 random echo");
        else if (m == 1) do_read(m, a, (a > 57) ? "R5 random range" : "R4 random equalizer");
        else             do_read(m, a, "R6 random scratch");
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule